// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block fronts a small one-time-programmable fuse array and exposes it on a 32-bit register bus. Software sets supply and mode bits in a control register and a power register, writes an unlock value, and then writes data to a fuse word's bus address to burn it. Burning can only raise bits, so a second write to the same word ORs the new data into what is already there. The array is modelled in flip-flops. Each word has a primary copy, an optional duplicate copy and a lock bit. Error conditions gather in a sticky flag register that software clears by writing ones.

Requests arrive on a valid/ready channel. One request is accepted when `req_valid` and `req_ready` are both high at a rising clock edge. Its response shows up on `rsp_valid`/`rsp_rdata` in the next cycle. The response stays on the port until `rsp_ready` takes it. While a response is waiting and `rsp_ready` is low, `req_ready` drops, so back-pressure on the response side stalls the request side. Only one request is ever outstanding. Every request, reads and writes alike, returns exactly one response. A write always responds with zero data.

Top module: `otp_word_ctrl`

## Requirements
- R1: An accepted request yields `rsp_valid` on the next cycle. A response not taken (`rsp_ready` low) keeps `rsp_valid` and `rsp_rdata` unchanged. `req_ready` is high whenever no response is pending. Each request gets exactly one response, in order.
- R2: After reset every register reads zero. Register map:
  - 0x20 holds the mode bits [4:0]: bit0 read supply, bit1 verify, bit2 duplicate, bit3 margin read, bit4 lock mode.
  - 0x24 reads the error flags.
  - 0x28 is the clear register and reads 0.
  - 0x2C holds the 32-bit unlock value.
  - 0x54 holds the power bits [2:0]: bit0 and bit1 are programming supplies, bit2 is program enable.
  - Unwritten bits read 0. Unmapped addresses read 0. Write responses carry 0.
- R3: A fuse-word write programs only when the unlock register holds 0x8810 and power bits 0, 1 and 2 are all set. Otherwise the word is unchanged and error bit0 is set.
- R4: Programming ORs the written data into the stored word, so bits never return to 0.
- R5: With mode bit2 set during programming, the duplicate copy is ORed as well. A read with bit2 set returns primary OR duplicate.
- R6: A fuse read with mode bit0 clear returns 0 and sets error bit2. With bit0 set and bit2 clear, the read returns the primary copy.
- R7: A fuse read with mode bits 0 and 2 set, where the two copies differ, sets error bit3.
- R8: A successful program with mode bit1 set reads the word back. It sets error bit1 if the word lacks any written bit, or if bit2 is set and the two copies differ afterwards.
- R9: A fuse write with mode bit4 set and the gate of R3 open sets that word's lock and leaves its data unchanged. Later data writes to a locked word are rejected with error bit0. Other words are unaffected.
- R10: Writing 0x28 clears each error flag whose bit [13:0] is 1 and leaves the others. Error bits 13:4 always read 0.
- R11: Fuse words 72 to 95 sit at 0x1000 + 4*n. Writes to window addresses outside that range change nothing and set no flag, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |

## Verification
The hardest condition to reach is a verify failure. Fuses only gain bits, so a programmed word always contains its data. The failure can therefore only come from a duplicate copy that has fallen behind the primary. The stimulus programs a word with duplication on, burns one more bit into it with duplication off, and then programs it again with verify and duplication both on. That final write must raise the verify flag. The copy-disagreement flag on read is reached by the same divergence. The response channel is throttled in a repeating pattern throughout, so requests land both while the channel is free and while it is stalled.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ERR_W  = 14;

  localparam logic [ADDR_W-1:0] A_MODE  = 16'h0020;
  localparam logic [ADDR_W-1:0] A_FLAGS = 16'h0024;
  localparam logic [ADDR_W-1:0] A_CLEAR = 16'h0028;
  localparam logic [ADDR_W-1:0] A_KEY   = 16'h002C;
  localparam logic [ADDR_W-1:0] A_POWER = 16'h0054;
  localparam logic [ADDR_W-1:0] A_WIN   = 16'h1000;

  localparam logic [DATA_W-1:0] UNLOCK_VALUE = 32'h0000_8810;

  // mode register, bit4 down to bit0
  typedef struct packed {
    logic lock_mode;
    logic margin;
    logic dup;
    logic verify;
    logic rd_sup;
  } mode_t;

  // power register, bit2 down to bit0
  typedef struct packed {
    logic prog_en;
    logic sup_b;
    logic sup_a;
  } power_t;

  localparam int F_GATE   = 0;
  localparam int F_VERIFY = 1;
  localparam int F_NOSUP  = 2;
  localparam int F_DUP    = 3;
endpackage

// File: rtl/otp_decode.sv
module otp_decode
  import otp_pkg::*;
#(
  parameter int NUM_WORDS  = 24,
  parameter int FIRST_WORD = 72,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mode,
  output logic              hit_flags,
  output logic              hit_clear,
  output logic              hit_key,
  output logic              hit_power,
  output logic              hit_win,
  output logic [IDX_W-1:0]  idx
);
  localparam int WN_W = ADDR_W - 2;
  localparam logic [WN_W-1:0] LO = WN_W'(FIRST_WORD);
  localparam logic [WN_W-1:0] HI = WN_W'(FIRST_WORD + NUM_WORDS);

  logic [ADDR_W-1:0] off;
  logic [WN_W-1:0]   wnum;
  logic [WN_W-1:0]   rel;

  always_comb begin
    off  = addr - A_WIN;
    wnum = off[ADDR_W-1:2];
    rel  = wnum - LO;
  end

  assign hit_mode  = (addr == A_MODE);
  assign hit_flags = (addr == A_FLAGS);
  assign hit_clear = (addr == A_CLEAR);
  assign hit_key   = (addr == A_KEY);
  assign hit_power = (addr == A_POWER);
  assign hit_win   = (addr >= A_WIN) && (wnum >= LO) && (wnum < HI);
  assign idx       = rel[IDX_W-1:0];
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              hit_mode,
  input  logic              hit_clear,
  input  logic              hit_key,
  input  logic              hit_power,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ERR_W-1:0]  flag_set,
  output mode_t             mode_q,
  output power_t            power_q,
  output logic [DATA_W-1:0] key_q,
  output logic [ERR_W-1:0]  flags_q
);
  logic [ERR_W-1:0] clr_mask;

  assign clr_mask = (we && hit_clear) ? wdata[ERR_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      power_q <= '0;
      key_q   <= '0;
      flags_q <= '0;
    end else begin
      if (we && hit_mode)  mode_q  <= mode_t'(wdata[$bits(mode_t)-1:0]);
      if (we && hit_power) power_q <= power_t'(wdata[$bits(power_t)-1:0]);
      if (we && hit_key)   key_q   <= wdata;
      flags_q <= (flags_q & ~clr_mask) | flag_set;
    end
  end
endmodule

// File: rtl/otp_cell.sv
module otp_cell
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              burn,
  input  logic              burn_dup,
  input  logic              lock_set,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] cpy_q,
  output logic              lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '0;
      cpy_q  <= '0;
      lock_q <= 1'b0;
    end else if (sel) begin
      if (burn)             pri_q  <= pri_q | data;
      if (burn && burn_dup) cpy_q  <= cpy_q | data;
      if (lock_set)         lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int NUM_WORDS = 24,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              burn,
  input  logic              burn_dup,
  input  logic              lock_set,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] cpy_q,
  output logic              lock_q
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] pri_all;
  logic [NUM_WORDS-1:0][DATA_W-1:0] cpy_all;
  logic [NUM_WORDS-1:0]             lock_all;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    otp_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (idx == IDX_W'(g)),
      .burn     (burn),
      .burn_dup (burn_dup),
      .lock_set (lock_set),
      .data     (data),
      .pri_q    (pri_all[g]),
      .cpy_q    (cpy_all[g]),
      .lock_q   (lock_all[g])
    );
  end

  always_comb begin
    pri_q  = '0;
    cpy_q  = '0;
    lock_q = 1'b0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx == IDX_W'(i)) begin
        pri_q  = pri_all[i];
        cpy_q  = cpy_all[i];
        lock_q = lock_all[i];
      end
    end
  end
endmodule

// File: rtl/otp_word_ctrl.sv
module otp_word_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_WORDS  = 24,
  parameter int FIRST_WORD = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic hit_mode, hit_flags, hit_clear, hit_key, hit_power, hit_win;
  logic [IDX_W-1:0] idx;

  mode_t             mode_q;
  power_t            power_q;
  logic [DATA_W-1:0] key_q;
  logic [ERR_W-1:0]  flags_q;
  logic [ERR_W-1:0]  flag_set;

  logic [DATA_W-1:0] pri_q, cpy_q, nx_pri, nx_cpy;
  logic              lock_q;

  logic acc, wr_acc, fuse_wr, fuse_rd, gate_open;
  logic burn, lock_set, reject, verify_bad, rd_nosup, rd_split;
  logic rd_sup;
  logic [DATA_W-1:0] fuse_data, rd_mux;

  otp_decode #(.NUM_WORDS(NUM_WORDS), .FIRST_WORD(FIRST_WORD)) u_dec (
    .addr      (req_addr),
    .hit_mode  (hit_mode),
    .hit_flags (hit_flags),
    .hit_clear (hit_clear),
    .hit_key   (hit_key),
    .hit_power (hit_power),
    .hit_win   (hit_win),
    .idx       (idx)
  );

  // request acceptance
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign fuse_wr   = wr_acc && hit_win;
  assign fuse_rd   = acc && !req_write && hit_win;
  assign rd_sup    = mode_q.rd_sup;

  // programming gate
  assign gate_open = (key_q == UNLOCK_VALUE) && power_q.sup_a
                     && power_q.sup_b && power_q.prog_en;
  assign lock_set  = fuse_wr && gate_open && mode_q.lock_mode;
  assign burn      = fuse_wr && gate_open && !mode_q.lock_mode && !lock_q;
  assign reject    = fuse_wr && (!gate_open || (!mode_q.lock_mode && lock_q));

  // read back of the word as it will stand after the burn
  assign nx_pri     = pri_q | req_wdata;
  assign nx_cpy     = mode_q.dup ? (cpy_q | req_wdata) : cpy_q;
  assign verify_bad = burn && mode_q.verify &&
                      (((nx_pri & req_wdata) != req_wdata) ||
                       (mode_q.dup && (nx_pri != nx_cpy)));

  assign rd_nosup = fuse_rd && !mode_q.rd_sup;
  assign rd_split = fuse_rd && mode_q.rd_sup && mode_q.dup && (pri_q != cpy_q);

  always_comb begin
    flag_set           = '0;
    flag_set[F_GATE]   = reject;
    flag_set[F_VERIFY] = verify_bad;
    flag_set[F_NOSUP]  = rd_nosup;
    flag_set[F_DUP]    = rd_split;
  end

  otp_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_acc),
    .hit_mode  (hit_mode),
    .hit_clear (hit_clear),
    .hit_key   (hit_key),
    .hit_power (hit_power),
    .wdata     (req_wdata),
    .flag_set  (flag_set),
    .mode_q    (mode_q),
    .power_q   (power_q),
    .key_q     (key_q),
    .flags_q   (flags_q)
  );

  otp_array #(.NUM_WORDS(NUM_WORDS)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx),
    .burn     (burn),
    .burn_dup (mode_q.dup),
    .lock_set (lock_set),
    .data     (req_wdata),
    .pri_q    (pri_q),
    .cpy_q    (cpy_q),
    .lock_q   (lock_q)
  );

  // read data selection
  always_comb begin
    if (!mode_q.rd_sup)  fuse_data = '0;
    else if (mode_q.dup) fuse_data = pri_q | cpy_q;
    else                 fuse_data = pri_q;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_win)        rd_mux = fuse_data;
    else if (hit_mode)  rd_mux = DATA_W'(mode_q);
    else if (hit_flags) rd_mux = DATA_W'(flags_q);
    else if (hit_key)   rd_mux = key_q;
    else if (hit_power) rd_mux = DATA_W'(power_q);
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/otp_word_ctrl_sva.sv
module otp_word_ctrl_sva
  import otp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              hit_win,
  input logic              hit_flags,
  input logic              rd_sup,
  input logic [DATA_W-1:0] key_q,
  input logic [ERR_W-1:0]  flags_q
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_free_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  assert_wr_rsp_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_rdata == '0));

  assert_gate_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && hit_win && (key_q != UNLOCK_VALUE))
      |=> flags_q[F_GATE]);

  assert_nosup_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && hit_win && !rd_sup)
      |=> (rsp_rdata == '0));

  assert_reserved_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && hit_flags)
      |=> (rsp_rdata[DATA_W-1:4] == '0));
endmodule

bind otp_word_ctrl otp_word_ctrl_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .hit_win   (hit_win),
  .hit_flags (hit_flags),
  .rd_sup    (rd_sup),
  .key_q     (key_q),
  .flags_q   (flags_q)
);

// File: tb/otp_word_ctrl_tb_top.sv
`timescale 1ns/100ps
module otp_word_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int n_req = 0;
  int n_rsp = 0;
  int cyc = 0;
  bit done = 0;
  logic        held_v = 1'b0;
  logic [31:0] held_d = '0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [15:0] MODE = 16'h0020, FLAGS = 16'h0024, CLEAR = 16'h0028,
                          KEY = 16'h002C, POWER = 16'h0054;

  always #2.5 clk = ~clk;

  otp_word_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [15:0] waddr(input int n);
    return 16'(16'h1000 + 4 * n);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag);
    exp_q.push_back(wr ? 32'h0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    n_req++;
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    do_req(1'b1, a, d, 32'h0, tag);
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    do_req(1'b0, a, 32'h0, exp, tag);
  endtask

  // monitor: throttles the response side and scores responses
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (held_v) begin
        check("R1 held response valid", {31'b0, rsp_valid}, 32'h1);
        check("R1 held response data", rsp_rdata, held_d);
      end
      rsp_ready = ((cyc % 7) != 3) && ((cyc % 7) != 4);
      held_v = rsp_valid && !rsp_ready;
      held_d = rsp_rdata;
      if (rsp_valid && rsp_ready) begin
        n_rsp++;
        if (exp_q.size() == 0) begin
          check("R1 unexpected response", 32'h1, 32'h0);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 reset req_ready", {31'b0, req_ready}, 32'h1);
    rst_n = 1'b1;

    // R2 register map and reset values
    rd(MODE, 0, "R2 mode reset");
    rd(FLAGS, 0, "R2 flags reset");
    rd(KEY, 0, "R2 key reset");
    rd(POWER, 0, "R2 power reset");
    wr(MODE, 32'h1F, "R2");
    rd(MODE, 32'h1F, "R2 mode readback");
    wr(MODE, 32'hFFFF_FFE0, "R2");
    rd(MODE, 32'h0, "R2 mode width");
    wr(POWER, 32'hFF, "R2");
    rd(POWER, 32'h7, "R2 power width");
    rd(CLEAR, 0, "R2 clear reads zero");
    rd(16'h0030, 0, "R2 unmapped");

    // R3 gate closed: no key
    wr(MODE, 1, "R3");
    wr(KEY, 0, "R3");
    wr(waddr(72), 32'hA5, "R3");
    rd(FLAGS, 1, "R3 no key flag");
    wr(CLEAR, 32'h3FFF, "R10");
    rd(FLAGS, 0, "R10 full clear");
    rd(waddr(72), 0, "R3 word unchanged no key");
    // R3 gate closed: program enable missing
    wr(KEY, 32'h8810, "R3");
    rd(KEY, 32'h8810, "R2 key readback");
    wr(POWER, 3, "R3");
    wr(waddr(72), 32'hA5, "R3");
    rd(FLAGS, 1, "R3 no prog enable flag");
    wr(CLEAR, 1, "R10");
    rd(waddr(72), 0, "R3 word unchanged no enable");

    // R4 OR-only programming
    wr(POWER, 7, "R4");
    wr(waddr(72), 32'hF0, "R4");
    rd(waddr(72), 32'hF0, "R4 first burn");
    wr(waddr(72), 32'h0F00_000F, "R4");
    rd(waddr(72), 32'h0F00_00FF, "R4 accumulate");
    rd(FLAGS, 0, "R4 no flags");

    // R6 read supply off
    wr(MODE, 0, "R6");
    rd(waddr(72), 0, "R6 supply off reads zero");
    rd(FLAGS, 4, "R6 supply flag");
    wr(MODE, 1, "R6");
    wr(CLEAR, 4, "R10");
    rd(FLAGS, 0, "R10 cleared supply flag");

    // R5 duplicate, R7 copy disagreement
    wr(MODE, 5, "R5");
    wr(waddr(73), 32'h1234, "R5");
    rd(waddr(73), 32'h1234, "R5 dup read");
    rd(FLAGS, 0, "R5 copies agree");
    wr(MODE, 1, "R7");
    wr(waddr(73), 32'h8000_0000, "R7");
    rd(waddr(73), 32'h8000_1234, "R6 primary only");
    wr(MODE, 5, "R7");
    rd(waddr(73), 32'h8000_1234, "R5 or of copies");
    rd(FLAGS, 8, "R7 disagreement flag");
    wr(CLEAR, 8, "R10");

    // R8 verify
    wr(MODE, 7, "R8");
    wr(waddr(73), 32'h1, "R8");
    rd(FLAGS, 2, "R8 verify mismatch");
    wr(CLEAR, 2, "R10");
    wr(waddr(74), 32'h55, "R8");
    rd(FLAGS, 0, "R8 clean verify");
    rd(waddr(74), 32'h55, "R8 word burned");

    // R9 lock
    wr(MODE, 32'h11, "R9");
    wr(waddr(74), 32'hFFFF, "R9");
    wr(MODE, 1, "R9");
    rd(waddr(74), 32'h55, "R9 lock write keeps data");
    rd(FLAGS, 0, "R9 lock write no flag");
    wr(waddr(74), 32'h100, "R9");
    rd(FLAGS, 1, "R9 locked reject flag");
    rd(waddr(74), 32'h55, "R9 locked word unchanged");
    wr(CLEAR, 1, "R10");
    wr(waddr(75), 32'h100, "R9");
    rd(waddr(75), 32'h100, "R9 neighbour programmable");
    rd(FLAGS, 0, "R9 neighbour no flag");

    // R11 window edges
    wr(waddr(96), 32'hFFFF, "R11");
    rd(waddr(96), 0, "R11 above window");
    rd(waddr(71), 0, "R11 below window");
    rd(FLAGS, 0, "R11 no flag outside");
    wr(waddr(95), 32'hDEAD_0000, "R11");
    rd(waddr(95), 32'hDEAD_0000, "R11 last word");

    // R3 key cleared blocks, R10 partial clear
    wr(KEY, 0, "R3");
    wr(waddr(72), 32'h1, "R3");
    rd(waddr(72), 32'h0F00_00FF, "R3 key cleared blocks");
    wr(MODE, 0, "R10");
    rd(waddr(72), 0, "R6 supply off again");
    rd(FLAGS, 5, "R10 two flags");
    wr(CLEAR, 1, "R10");
    rd(FLAGS, 4, "R10 partial clear");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R1 one response per request", 32'(n_rsp), 32'(n_req));
    finish_run();
  end
endmodule